// File: doc/BRIEF.md
# Counter Affinity Allocator

This block hands out hardware event counters from a bank of ten. A requester presents an 8-bit event code. The block looks up which counters may count that event, because counters are not interchangeable. It then grants the lowest-numbered allowed counter that is currently idle and records that counter as occupied. If every allowed counter is occupied, it reports a failure, and the requester is expected to retry later. A separate release input returns a counter to the idle pool by its index.

Each answer appears one clock after the request. It is a pulse on `rsp_valid`, together with `rsp_fail` and a 4-bit counter index. An allocation and a release may arrive in the same cycle, and both take effect. The allocation sees the occupancy from before that cycle's release.

Top module: `ctr_affinity_alloc`

## Requirements
- R1: After reset, all ten counters are idle and `rsp_valid` is low.
- R2: An event code with no specific rule may be placed only on counters 2 to 9. Examples are 0x00, 0x33, 0x55 and 0xFF.
- R3: Event 0x02 (core cycles) may be placed on counter 0 or on any of counters 2 to 9.
- R4: Event 0x8C (all instructions) may be placed only on counters 1 and 7.
- R5: The following events may be placed only on counters 5, 6 and 7:
  - branch and barrier events 0x8D, 0x8E, 0x8F, 0x90, 0x93, 0x94, 0x95, 0x98, 0x99 and 0x9C;
  - non-speculative events 0xBF, 0xC0, 0xC1, 0xC4, 0xC5, 0xC6, 0xC8, 0xCA and 0xCB.
- R6: Events 0x01, 0x96, 0x97, 0x9A, 0x9B and 0x9F may be placed only on counter 7.
- R7: Events 0xF5, 0xF6, 0xF7 and 0xFD may use only counters 2, 4 and 6. Event 0xF8 may use only counters 2 to 7.
- R8: An allocation request produces exactly one `rsp_valid` pulse on the next clock and no other cycle does. A successful response carries the lowest-indexed counter that is both allowed and idle, and that counter becomes occupied.
- R9: When no allowed counter is idle, the response has `rsp_fail` high and index 0, and occupancy is unchanged.
- R10: A release makes only the named counter idle again.
- R11: A release of an idle counter, or of an index of 10 or more, has no effect.
- R12: An allocation and a release in the same cycle are both applied. The allocation chooses from the occupancy that was in place before that release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| alloc_req | input | 1 | Allocation request, one cycle per request |
| alloc_evt | input | 8 | Event code of the request |
| rel_req | input | 1 | Release request |
| rel_idx | input | 4 | Counter index to release |
| rsp_valid | output | 1 | Response pulse, one cycle after a request |
| rsp_fail | output | 1 | No allowed counter was idle |
| rsp_idx | output | 4 | Granted counter index (0 on failure) |

## Verification
The properties take for granted that the request inputs hold known values whenever reset is released. They also assume that `alloc_evt` is meaningful only in the cycle where `alloc_req` is high. `rel_idx` may carry any value, including indices beyond the bank. The stimulus drives every input on the falling clock edge and holds each request high for exactly one cycle. It clears both request lines between operations, so each response maps to a single request.

// File: rtl/ctr_affinity_alloc.sv
module ctr_affinity_alloc #(
  parameter int CNT  = 10,
  parameter int EVW  = 8,
  parameter int IDXW = $clog2(CNT)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            alloc_req,
  input  logic [EVW-1:0]  alloc_evt,
  input  logic            rel_req,
  input  logic [IDXW-1:0] rel_idx,
  output logic            rsp_valid,
  output logic            rsp_fail,
  output logic [IDXW-1:0] rsp_idx
);

  function automatic logic [CNT-1:0] span(input int lo, input int hi);
    logic [CNT-1:0] m;
    m = '0;
    for (int i = 0; i < CNT; i++)
      if (i >= lo && i <= hi) m[i] = 1'b1;
    return m;
  endfunction

  function automatic logic [CNT-1:0] one(input int k);
    return span(k, k);
  endfunction

  function automatic logic [CNT-1:0] affinity(input logic [EVW-1:0] e);
    logic [CNT-1:0] m;
    case (e)
      8'h02: m = span(2, 9) | one(0);
      8'h8C: m = one(1) | one(7);
      8'h01, 8'h96, 8'h97, 8'h9A, 8'h9B, 8'h9F: m = one(7);
      8'h8D, 8'h8E, 8'h8F, 8'h90, 8'h93, 8'h94, 8'h95, 8'h98, 8'h99, 8'h9C,
      8'hBF, 8'hC0, 8'hC1, 8'hC4, 8'hC5, 8'hC6, 8'hC8, 8'hCA, 8'hCB:
        m = span(5, 7);
      8'hF5, 8'hF6, 8'hF7, 8'hFD: m = one(2) | one(4) | one(6);
      8'hF8: m = span(2, 7);
      default: m = span(2, 9);
    endcase
    return m;
  endfunction

  logic [CNT-1:0]  used_q;
  logic [CNT-1:0]  cand;
  logic [CNT-1:0]  grant_bit;
  logic [CNT-1:0]  rel_bit;
  logic [IDXW-1:0] pick;

  assign cand = affinity(alloc_evt) & ~used_q;

  always_comb begin
    pick = '0;
    for (int i = CNT - 1; i >= 0; i--)
      if (cand[i]) pick = IDXW'(i);
  end

  assign grant_bit = (alloc_req && cand != '0) ? (CNT'(1) << pick) : '0;
  assign rel_bit   = (rel_req && rel_idx < IDXW'(CNT)) ? (CNT'(1) << rel_idx) : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      used_q    <= '0;
      rsp_valid <= 1'b0;
      rsp_fail  <= 1'b0;
      rsp_idx   <= '0;
    end else begin
      used_q    <= (used_q & ~rel_bit) | grant_bit;
      rsp_valid <= alloc_req;
      rsp_fail  <= alloc_req && cand == '0;
      rsp_idx   <= (alloc_req && cand != '0) ? pick : '0;
    end
  end

endmodule

// File: rtl/ctr_affinity_alloc_chk.sv
module ctr_affinity_alloc_chk #(
  parameter int CNT  = 10,
  parameter int EVW  = 8,
  parameter int IDXW = $clog2(CNT)
) (
  input logic            clk,
  input logic            rst_n,
  input logic            alloc_req,
  input logic [EVW-1:0]  alloc_evt,
  input logic            rel_req,
  input logic [IDXW-1:0] rel_idx,
  input logic            rsp_valid,
  input logic            rsp_fail,
  input logic [IDXW-1:0] rsp_idx,
  input logic [CNT-1:0]  used
);

  function automatic logic bit_at(input logic [CNT-1:0] v, input logic [IDXW-1:0] i);
    return ((v >> i) & CNT'(1)) != '0;
  endfunction

  AST_REQ_RESPONDS: assert property (@(posedge clk) disable iff (!rst_n) alloc_req |=> rsp_valid); // R8
  AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n) !alloc_req |=> !rsp_valid); // R8
  AST_GRANT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n) (rsp_valid && !rsp_fail) |-> rsp_idx < IDXW'(CNT)); // R8
  AST_GRANT_WAS_IDLE: assert property (@(posedge clk) disable iff (!rst_n) (rsp_valid && !rsp_fail) |-> !bit_at($past(used), rsp_idx)); // R8
  AST_GRANT_MARKED: assert property (@(posedge clk) disable iff (!rst_n) (rsp_valid && !rsp_fail) |-> bit_at(used, rsp_idx)); // R8
  AST_FAIL_IDX_ZERO: assert property (@(posedge clk) disable iff (!rst_n) (rsp_valid && rsp_fail) |-> rsp_idx == '0); // R9
  AST_FAIL_KEEPS_MASK: assert property (@(posedge clk) disable iff (!rst_n) (rsp_valid && rsp_fail && !$past(rel_req)) |-> used == $past(used)); // R9
  AST_CTR0_CYCLES_ONLY: assert property (@(posedge clk) disable iff (!rst_n) (rsp_valid && !rsp_fail && rsp_idx == '0) |-> $past(alloc_evt) == 8'h02); // R3
  AST_CTR1_INSTR_ONLY: assert property (@(posedge clk) disable iff (!rst_n) (rsp_valid && !rsp_fail && rsp_idx == IDXW'(1)) |-> $past(alloc_evt) == 8'h8C); // R4
  AST_RELEASE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n) (rel_req && !alloc_req && rel_idx < IDXW'(CNT)) |=> !bit_at(used, $past(rel_idx))); // R10

endmodule

bind ctr_affinity_alloc ctr_affinity_alloc_chk #(.CNT(CNT), .EVW(EVW), .IDXW(IDXW)) u_chk (
  .clk(clk), .rst_n(rst_n), .alloc_req(alloc_req), .alloc_evt(alloc_evt),
  .rel_req(rel_req), .rel_idx(rel_idx), .rsp_valid(rsp_valid),
  .rsp_fail(rsp_fail), .rsp_idx(rsp_idx), .used(used_q)
);

// File: tb/ctr_affinity_alloc_bench.sv
module ctr_affinity_alloc_bench;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       alloc_req = 1'b0;
  logic [7:0] alloc_evt = '0;
  logic       rel_req = 1'b0;
  logic [3:0] rel_idx = '0;
  logic       rsp_valid;
  logic       rsp_fail;
  logic [3:0] rsp_idx;

  int tests = 0;
  int fails = 0;

  always #5 clk = ~clk;

  ctr_affinity_alloc u_ctr_affinity_alloc (
    .clk(clk), .rst_n(rst_n), .alloc_req(alloc_req), .alloc_evt(alloc_evt),
    .rel_req(rel_req), .rel_idx(rel_idx), .rsp_valid(rsp_valid),
    .rsp_fail(rsp_fail), .rsp_idx(rsp_idx)
  );

  // {op[1:0] (1 alloc, 2 release, 3 both), evt[7:0], rel[3:0], fail, idx[3:0], req[4:0]}
  localparam int NV = 31;
  localparam logic [23:0] VEC [NV] = '{
    {2'd1, 8'h02, 4'd0,  1'b0, 4'd0, 5'd3},   // R3
    {2'd1, 8'h02, 4'd0,  1'b0, 4'd2, 5'd3},   // R3
    {2'd1, 8'h8C, 4'd0,  1'b0, 4'd1, 5'd4},   // R4
    {2'd1, 8'h8C, 4'd0,  1'b0, 4'd7, 5'd4},   // R4
    {2'd1, 8'h8C, 4'd0,  1'b1, 4'd0, 5'd4},   // R4
    {2'd1, 8'h01, 4'd0,  1'b1, 4'd0, 5'd6},   // R6
    {2'd1, 8'h33, 4'd0,  1'b0, 4'd3, 5'd2},   // R2
    {2'd1, 8'h8D, 4'd0,  1'b0, 4'd5, 5'd5},   // R5
    {2'd1, 8'hCB, 4'd0,  1'b0, 4'd6, 5'd5},   // R5
    {2'd1, 8'h9C, 4'd0,  1'b1, 4'd0, 5'd5},   // R5
    {2'd1, 8'hF5, 4'd0,  1'b0, 4'd4, 5'd7},   // R7
    {2'd1, 8'hFD, 4'd0,  1'b1, 4'd0, 5'd7},   // R7
    {2'd1, 8'hF8, 4'd0,  1'b1, 4'd0, 5'd7},   // R7
    {2'd1, 8'h00, 4'd0,  1'b0, 4'd8, 5'd2},   // R2
    {2'd1, 8'hFF, 4'd0,  1'b0, 4'd9, 5'd2},   // R2
    {2'd1, 8'h02, 4'd0,  1'b1, 4'd0, 5'd9},   // R9
    {2'd2, 8'h00, 4'd7,  1'b0, 4'd0, 5'd10},  // R10
    {2'd1, 8'h97, 4'd0,  1'b0, 4'd7, 5'd6},   // R6
    {2'd1, 8'h00, 4'd0,  1'b1, 4'd0, 5'd10},  // R10
    {2'd2, 8'h00, 4'd4,  1'b0, 4'd0, 5'd10},  // R10
    {2'd2, 8'h00, 4'd4,  1'b0, 4'd0, 5'd11},  // R11
    {2'd1, 8'hF6, 4'd0,  1'b0, 4'd4, 5'd7},   // R7
    {2'd1, 8'hF7, 4'd0,  1'b1, 4'd0, 5'd11},  // R11
    {2'd2, 8'h00, 4'd15, 1'b0, 4'd0, 5'd11},  // R11
    {2'd1, 8'h00, 4'd0,  1'b1, 4'd0, 5'd11},  // R11
    {2'd3, 8'h00, 4'd3,  1'b1, 4'd0, 5'd12},  // R12
    {2'd1, 8'h00, 4'd0,  1'b0, 4'd3, 5'd12},  // R12
    {2'd2, 8'h00, 4'd9,  1'b0, 4'd0, 5'd10},  // R10
    {2'd3, 8'h55, 4'd8,  1'b0, 4'd9, 5'd12},  // R12
    {2'd1, 8'h55, 4'd0,  1'b0, 4'd8, 5'd12},  // R12
    {2'd1, 8'h01, 4'd0,  1'b1, 4'd0, 5'd6}    // R6
  };

  task automatic check(input int req, input logic v, input logic f, input logic [3:0] i,
                       input logic ev, input logic ef, input logic [3:0] ei);
    tests++;
    if (v !== ev || (ev && (f !== ef || i !== ei))) begin
      fails++;
      $display("FAIL R%0d: valid=%0b fail=%0b idx=%0d, expected valid=%0b fail=%0b idx=%0d",
               req, v, f, i, ev, ef, ei);
    end
  endtask

  task automatic op(input logic a, input logic [7:0] e, input logic r, input logic [3:0] ri,
                    input int req, input logic ef, input logic [3:0] ei);
    @(negedge clk);
    alloc_req = a; alloc_evt = e; rel_req = r; rel_idx = ri;
    @(negedge clk);
    check(req, rsp_valid, rsp_fail, rsp_idx, a, ef, ei);
    alloc_req = 1'b0; rel_req = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(1, rsp_valid, rsp_fail, rsp_idx, 1'b0, 1'b0, 4'd0);   // R1
    rst_n = 1'b1;
    for (int k = 0; k < NV; k++) begin
      logic [23:0] w;
      w = VEC[k];
      op(w[22], w[21:14], w[23], w[13:10], int'(w[4:0]), w[9], w[8:5]);
    end
    @(negedge clk);
    check(8, rsp_valid, rsp_fail, rsp_idx, 1'b0, 1'b0, 4'd0);   // R8 idle cycle
    op(1'b1, 8'h97, 1'b0, 4'd0, 8, 1'b1, 4'd0);                 // R8 counter 7 still busy
    rst_n = 1'b0;
    @(negedge clk); @(negedge clk);
    check(1, rsp_valid, rsp_fail, rsp_idx, 1'b0, 1'b0, 4'd0);   // R1
    rst_n = 1'b1;
    op(1'b1, 8'h8C, 1'b0, 4'd0, 1, 1'b0, 4'd1);                 // R1 all idle again
    op(1'b1, 8'h01, 1'b0, 4'd0, 1, 1'b0, 4'd7);                 // R1
    op(1'b1, 8'hC5, 1'b0, 4'd0, 5, 1'b0, 4'd5);                 // R5
    op(1'b1, 8'hF8, 1'b0, 4'd0, 7, 1'b0, 4'd2);                 // R7
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    fails++;
    tests++;
    $display("FAIL watchdog: run did not end, expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule